// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers 64 level-sensitive request lines and turns them into two processor interrupt lines: a normal line and a fast line. Each source can be enabled or masked on its own, and a routing bit chooses which of the two lines it drives. For each line the block keeps a registered winner code that names the most urgent pending source. Software reads this code to learn which handler to run. A code of zero means that nothing is pending on that line.

Urgency is ranked by position, and the lowest source number wins. The upper bank of 32 sources can also be marked as errors. Any active, enabled error source beats every ordinary source on its line. The code it reports is still its own number, so marking a source as an error changes only which source wins, never the value reported for it. Software reaches all registers through a flat word-addressed port with separate read and write strobes. Reads are combinational and writes take effect on the clock edge.

Top module: `dualtier_intc`

## Requirements
- R1: The raw status words at offset 0x00 (sources 0..31, bit n = source n) and 0x20 (sources 32..63, bit n = source 32+n) hold the request lines as sampled on the previous clock edge.
- R2: The mask words at 0x04 (low bank) and 0x24 (high bank), the routing words at 0x08 and 0x28, and the error-mark word at 0x34 are read/write. Bit k of 0x34 marks source 32+k.
- R3: A routing bit of 1 sends its source to the fast line and 0 sends it to the normal line. Offset 0x2C reads status2 & mask2 & ~route2 and offset 0x30 reads status2 & mask2 & route2.
- R4: Among the eligible sources of a line (pending, enabled and routed to that line), the lowest-numbered one wins when no error-marked source is eligible.
- R5: An eligible source in 32..63 whose error bit is set wins over every eligible unmarked source of its line, whatever their numbers. Sources 0..31 can never be error-marked.
- R6: When several error-marked sources are eligible on one line, the lowest-numbered of them wins. The reported code is the same as it would be without the error mark.
- R7: The winner code for a source n is (n+1)<<2, so source 1 reads 0x00000008, and 0 means none. The normal-line code reads at 0x0C and the fast-line code at 0x10. Each code is registered from the status, mask, routing and error state of the previous cycle.
- R8: irq_o is high exactly when the normal-line code is nonzero, and fiq_o is high exactly when the fast-line code is nonzero.
- R9: After reset all registers and both codes read 0, and both output lines are low.
- R10: Writes to read-only offsets (0x00, 0x0C, 0x10, 0x20, 0x2C, 0x30) or to unmapped offsets change no register. Reading an unmapped offset, or reading while rd_en is low, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 64 | Level request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when rd_en is low |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The hardest situation to reach is a line where several error-marked high sources compete with lower-numbered ordinary sources at the same moment, and the error marks change while the requests stay steady. The stimulus builds this case directly. It holds low sources together with two marked high sources, then clears the marks and checks that the winner falls back to positional order. A long random phase then mixes random request words with random writes to mask, routing and error registers, and checks every cycle against a behavioural model.

// File: rtl/dualtier_intc.sv
module dualtier_intc #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       req_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int NSRC = 64;
  localparam int HALF = NSRC / 2;
  localparam logic [ADDR_W-1:0] OFS_ST1  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_EN1  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_SEL1 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_IRQC = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_FIQC = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_ST2  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFS_EN2  = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFS_SEL2 = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFS_IRQ2 = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFS_FIQ2 = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_ERR2 = ADDR_W'(8'h34);

  logic [NSRC-1:0] stat_all, en_all, sel_all;
  logic [HALF-1:0] err2;
  logic [31:0]     irq_code, fiq_code;

  wire [NSRC-1:0] err_mask = {err2, {HALF{1'b0}}};
  wire [NSRC-1:0] elig_irq = stat_all & en_all & ~sel_all;
  wire [NSRC-1:0] elig_fiq = stat_all & en_all &  sel_all;

  function automatic logic [31:0] pick_code(input logic [NSRC-1:0] elig,
                                            input logic [NSRC-1:0] em);
    logic [NSRC-1:0] pool;
    logic [31:0]     c;
    pool = ((elig & em) != '0) ? (elig & em) : elig;
    c = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pool[i]) c = 32'((i + 1) << 2);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_all <= '0;
      irq_code <= '0;
      fiq_code <= '0;
    end else begin
      stat_all <= req_i;
      irq_code <= pick_code(elig_irq, err_mask);
      fiq_code <= pick_code(elig_fiq, err_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_all  <= '0;
      sel_all <= '0;
      err2    <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_EN1:  en_all[HALF-1:0]     <= wdata;
        OFS_SEL1: sel_all[HALF-1:0]    <= wdata;
        OFS_EN2:  en_all[NSRC-1:HALF]  <= wdata;
        OFS_SEL2: sel_all[NSRC-1:HALF] <= wdata;
        OFS_ERR2: err2                 <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_ST1:  rdata = stat_all[HALF-1:0];
        OFS_EN1:  rdata = en_all[HALF-1:0];
        OFS_SEL1: rdata = sel_all[HALF-1:0];
        OFS_IRQC: rdata = irq_code;
        OFS_FIQC: rdata = fiq_code;
        OFS_ST2:  rdata = stat_all[NSRC-1:HALF];
        OFS_EN2:  rdata = en_all[NSRC-1:HALF];
        OFS_SEL2: rdata = sel_all[NSRC-1:HALF];
        OFS_IRQ2: rdata = elig_irq[NSRC-1:HALF];
        OFS_FIQ2: rdata = elig_fiq[NSRC-1:HALF];
        OFS_ERR2: rdata = err2;
        default:  rdata = '0;
      endcase
    end
  end

  assign irq_o = irq_code != '0;
  assign fiq_o = fiq_code != '0;
endmodule

module dualtier_intc_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [63:0]       elig_irq,
  input logic [63:0]       elig_fiq,
  input logic [63:0]       err_mask,
  input logic [63:0]       en_all,
  input logic [63:0]       sel_all,
  input logic [31:0]       irq_code,
  input logic [31:0]       fiq_code
);
  a_r7_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
    irq_code[1:0] == 2'b00 && irq_code <= 32'd256 &&
    fiq_code[1:0] == 2'b00 && fiq_code <= 32'd256);

  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_irq == '0) |=> (irq_code == '0));

  a_r7_fiq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_fiq == '0) |=> (fiq_code == '0));

  a_r4_irq_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_irq != '0) |=> (irq_code != '0));

  a_r5_irq_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_irq & err_mask) != '0) |=> (irq_code > 32'd128));

  a_r5_fiq_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_fiq & err_mask) != '0) |=> (fiq_code > 32'd128));

  a_r3_lines_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code != '0 && fiq_code != '0) |-> (irq_code != fiq_code));

  a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == ADDR_W'(8'h00) || addr == ADDR_W'(8'h20) ||
               addr == ADDR_W'(8'h0C) || addr == ADDR_W'(8'h30)))
    |=> $stable({en_all, sel_all, err_mask}));
endmodule

bind dualtier_intc dualtier_intc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .elig_irq(elig_irq), .elig_fiq(elig_fiq), .err_mask(err_mask),
  .en_all(en_all), .sel_all(sel_all),
  .irq_code(irq_code), .fiq_code(fiq_code)
);

// File: tb/dualtier_intc_bench.sv
module dualtier_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req_i = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dualtier_intc u_dualtier_intc (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // behavioural reference
  logic [63:0] m_stat, m_en, m_sel;
  logic [31:0] m_err, m_ic, m_fc;

  function automatic logic [31:0] ref_code(input bit fast);
    int best = -1;
    int best_err = -1;
    int win;
    for (int n = 0; n < 64; n++) begin
      if (m_stat[n] && m_en[n] && (m_sel[n] == fast)) begin
        if (n >= 32 && m_err[n-32] && best_err < 0) best_err = n;
        if (best < 0) best = n;
      end
    end
    win = (best_err >= 0) ? best_err : best;
    return (win < 0) ? 32'd0 : 32'((win + 1) * 4);
  endfunction

  function automatic logic [31:0] ref_read(input logic [7:0] a);
    case (a)
      8'h00: return m_stat[31:0];
      8'h04: return m_en[31:0];
      8'h08: return m_sel[31:0];
      8'h0C: return m_ic;
      8'h10: return m_fc;
      8'h20: return m_stat[63:32];
      8'h24: return m_en[63:32];
      8'h28: return m_sel[63:32];
      8'h2C: return m_stat[63:32] & m_en[63:32] & ~m_sel[63:32];
      8'h30: return m_stat[63:32] & m_en[63:32] & m_sel[63:32];
      8'h34: return m_err;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h20: return "R1";
      8'h04, 8'h08, 8'h24, 8'h28, 8'h34: return "R2";
      8'h2C, 8'h30: return "R3";
      8'h0C, 8'h10: return "R7";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_en <= '0; m_sel <= '0; m_err <= '0;
      m_ic <= '0; m_fc <= '0;
    end else begin
      m_stat <= req_i;
      m_ic <= ref_code(1'b0);
      m_fc <= ref_code(1'b1);
      if (wr_en) begin
        case (addr)
          8'h04: m_en[31:0]  <= wdata;
          8'h08: m_sel[31:0] <= wdata;
          8'h24: m_en[63:32]  <= wdata;
          8'h28: m_sel[63:32] <= wdata;
          8'h34: m_err <= wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R8 irq_o", 32'(irq_o), 32'(m_ic != 0));
      check("R8 fiq_o", 32'(fiq_o), 32'(m_fc != 0));
      if (rd_en) check({tag_of(addr), " read"}, rdata, ref_read(addr));
      else check("R10 idle rdata", rdata, 32'd0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #2;
    check(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd(8'h0C, 32'd0, "R9 irq code after reset");
    rd(8'h10, 32'd0, "R9 fiq code after reset");
    rd(8'h04, 32'd0, "R9 mask after reset");
    rd(8'h34, 32'd0, "R9 err after reset");
    check("R9 irq_o low", 32'(irq_o), 32'd0);
    check("R9 fiq_o low", 32'(fiq_o), 32'd0);

    // R2 readback
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h04, 32'hFFFF_FFFF, "R2 mask1 readback");
    wr(8'h08, 32'hA5A5_0000);
    rd(8'h08, 32'hA5A5_0000, "R2 route1 readback");
    wr(8'h08, 32'h0);

    // R4 / R7: source 1 beats 5, code 0x8
    req_i = 64'h22;
    settle();
    rd(8'h00, 32'h22, "R1 status1");
    rd(8'h0C, 32'h8, "R7 source1 code");
    check("R8 irq_o high", 32'(irq_o), 32'd1);

    // R3 routing: source 40 to fast line, source 0 on normal line
    wr(8'h28, 32'h100);
    req_i = 64'h1 | (64'h1 << 40);
    settle();
    rd(8'h0C, 32'd4, "R4 source0 on irq");
    rd(8'h10, 32'd164, "R3 source40 on fiq");
    rd(8'h2C, 32'h0, "R3 irq view2");
    rd(8'h30, 32'h100, "R3 fiq view2");
    rd(8'h20, 32'h100, "R1 status2");
    wr(8'h28, 32'h0);

    // R5 / R6: errors on 50 and 60 beat source 3; lowest error wins
    req_i = (64'h1 << 3) | (64'h1 << 50) | (64'h1 << 60);
    wr(8'h34, (32'h1 << 18) | (32'h1 << 28));
    settle();
    rd(8'h0C, 32'd204, "R6 lowest error 50 wins");
    wr(8'h34, 32'h1 << 28);
    settle();
    rd(8'h0C, 32'd244, "R5 error 60 beats 3");
    wr(8'h34, 32'h0);
    settle();
    rd(8'h0C, 32'd16, "R6 unmarked falls back to 3");

    // R5 bit 0 maps to source 32
    req_i = (64'h1 << 2) | (64'h1 << 32);
    wr(8'h34, 32'h1);
    settle();
    rd(8'h0C, 32'd132, "R5 error bit0 is source32");
    wr(8'h34, 32'h0);

    // R4 masked source does not win
    wr(8'h04, 32'hFFFF_FFFB);
    settle();
    rd(8'h0C, 32'd132, "R4 masked source2 skipped");
    wr(8'h04, 32'hFFFF_FFFF);

    // R10 writes to read-only / unmapped offsets
    wr(8'h00, 32'h0); wr(8'h0C, 32'h0); wr(8'h10, 32'h0);
    wr(8'h20, 32'h0); wr(8'h2C, 32'h0); wr(8'h30, 32'h0);
    wr(8'h3C, 32'h1234_5678); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h04, 32'hFFFF_FFFF, "R10 mask1 unchanged");
    rd(8'h24, 32'hFFFF_FFFF, "R10 mask2 unchanged");
    rd(8'h34, 32'h0, "R10 err unchanged");
    rd(8'h3C, 32'h0, "R10 unmapped read");
    rd(8'h00, 32'h4, "R10 status1 unchanged");

    // random mix, checked every clock by the monitor
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      req_i = {$urandom, $urandom} & {$urandom, $urandom};
      wr_en = ($urandom % 4) == 0;
      rd_en = ($urandom % 2) == 0;
      case ($urandom % 12)
        0: addr = 8'h00;  1: addr = 8'h04;  2: addr = 8'h08;  3: addr = 8'h0C;
        4: addr = 8'h10;  5: addr = 8'h20;  6: addr = 8'h24;  7: addr = 8'h28;
        8: addr = 8'h2C;  9: addr = 8'h30;  10: addr = 8'h34; default: addr = 8'h18;
      endcase
      wdata = $urandom;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule